// File: doc/BRIEF.md
# Descriptor-List DMA Sequencer

This block is the per-channel control engine that feeds a DMA transfer unit from a table of descriptors held in memory. Software sets a table base address, the number of entries, a stage-interrupt index and a repeat mode through a small word-addressed register port. It then sets the enable bit. The engine reads each 16-byte entry through a simple memory read port and hands the source address, destination address and transfer count to the transfer unit as a one-cycle load. It then waits for the unit's done pulse and moves on to the next entry.

Progress can be read back as a current-entry index. A stage-end flag marks the completion of one chosen entry. A transfer-end flag marks the end of a single pass. In endless mode the index wraps to zero after the last entry and the transfer-end flag never rises. When descriptor mode is off, the engine performs a single transfer from three directly written registers. Each flag has its own interrupt enable, and the interrupt output is a level.

Top module: `desc_list_seq`

## Requirements

The register port is word-addressed: 0 = control, 1 = list control, 2 = table base, 3 = stage index, 4 = direct source, 5 = direct destination, 6 = direct count.

The control word holds these bits:
- bit 0: enable
- bit 1: transfer-end flag
- bit 2: stage-end flag
- bit 3: transfer-end interrupt enable
- bit 4: stage-end interrupt enable
- bit 5: endless mode

The list control word holds the entry count minus one in bits 31:24, the current index (read-only) in bits 23:16, and the index-reset strobe in bit 15.

- R1: After reset every register reads 0, and irq_o, mem_req_o and xfer_load_o are low.
- R2: For entry i, the engine reads four words in order at base+16*i, +4, +8 and +12. The load presents the first three words as source, destination and count. The fourth word is read and discarded.
- R3: Base register bits 31:4 give the table address; bits 3:1 are dropped and read as 0. Bit 0 selects descriptor mode (1) or direct mode (0).
- R4: The control write that takes enable from 0 to 1 starts the engine. In single-pass mode exactly count+1 loads follow, one per entry.
- R5: List control bits 23:16 read the current index, which equals count after a single pass ends. A write with bit 15 set returns the index to 0.
- R6: When the entry whose index equals the stage register completes, the stage-end flag (bit 2) is set. Rewriting the stage register moves the event to a later entry.
- R7: In single-pass mode the transfer-end flag (bit 1) rises only after the last entry completes. It drives irq_o only when bit 3 is set.
- R8: In endless mode (bit 5) the index wraps from count to 0 and fetching continues; the transfer-end flag never rises.
- R9: Writing 0 to a flag bit clears it; writing 1 leaves it unchanged.
- R10: A control write with enable 0 stops the channel at once, with no further reads or loads. Writing 0 to the whole control word halts and clears all its bits.
- R11: If a flag is set by hardware in the same cycle that software writes 0 to it, the flag ends up set.
- R12: In direct mode the engine loads the direct source, destination and count registers with no memory reads, and sets the transfer-end flag after done.
- R13: irq_o = (transfer-end AND bit 3) OR (stage-end AND bit 4). It is a level that stays high until software clears the flag or the enable.

## Ports

| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i |
| mem_req_o | output | 1 | Descriptor word read request |
| mem_addr_o | output | 32 | Descriptor word byte address |
| mem_rvalid_i | input | 1 | Read data valid for the current request |
| mem_rdata_i | input | 32 | Read data |
| xfer_load_o | output | 1 | One-cycle load of the transfer unit |
| xfer_src_o | output | 32 | Source address for the load |
| xfer_dst_o | output | 32 | Destination address for the load |
| xfer_cnt_o | output | 32 | Transfer count for the load |
| xfer_done_i | input | 1 | Transfer unit finished the current load |
| irq_o | output | 1 | Interrupt level |

## Verification

Software can write the control word in the same cycle that the transfer unit's done pulse completes the stage entry. In that cycle the stage-end flag is both set by hardware and cleared by software. The bench drives done and a control write with the stage-end bit at 0 on the same clock edge, then reads the control word back and requires bit 2 to be set. A second pairing is a stop write arriving while the engine is mid-list in endless mode. This is judged by counting the loads and read requests that follow it.

// File: rtl/dls_pkg.sv
package dls_pkg;
  localparam logic [2:0] RA_CTRL  = 3'd0;
  localparam logic [2:0] RA_LIST  = 3'd1;
  localparam logic [2:0] RA_BASE  = 3'd2;
  localparam logic [2:0] RA_STAGE = 3'd3;
  localparam logic [2:0] RA_SRC   = 3'd4;
  localparam logic [2:0] RA_DST   = 3'd5;
  localparam logic [2:0] RA_CNT   = 3'd6;

  localparam int B_EN   = 0;
  localparam int B_TE   = 1;
  localparam int B_SE   = 2;
  localparam int B_TIE  = 3;
  localparam int B_SIE  = 4;
  localparam int B_RPT  = 5;
  localparam int B_IRST = 15;
  localparam int B_MODE = 0;

  localparam int CNT_LSB = 24;
  localparam int IDX_LSB = 16;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_LOAD,
    ST_WAIT,
    ST_ADV
  } seq_state_e;
endpackage

// File: rtl/dls_regs.sv
module dls_regs
  import dls_pkg::*;
#(
  parameter int DW    = 32,
  parameter int IDX_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [2:0]        addr_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              stage_set_i,
  input  logic              te_set_i,
  output logic [DW-1:0]     rdata_o,
  output logic              en_o,
  output logic              rpt_o,
  output logic              dmode_o,
  output logic              te_o,
  output logic              se_o,
  output logic              tie_o,
  output logic              sie_o,
  output logic [DW-5:0]     base_o,
  output logic [IDX_W-1:0]  cnt_o,
  output logic [IDX_W-1:0]  stage_o,
  output logic [DW-1:0]     sar_o,
  output logic [DW-1:0]     dar_o,
  output logic [DW-1:0]     tcr_o,
  output logic              start_o,
  output logic              stop_o,
  output logic              idx_clr_o
);
  localparam int BASE_W = DW - 4;

  logic en_q, te_q, se_q, tie_q, sie_q, rpt_q, dmode_q;
  logic [BASE_W-1:0] base_q;
  logic [IDX_W-1:0]  cnt_q, stage_q;
  logic [DW-1:0]     sar_q, dar_q, tcr_q;

  logic wr_ctrl, wr_list, wr_base, wr_stage;
  assign wr_ctrl  = we_i && (addr_i == RA_CTRL);
  assign wr_list  = we_i && (addr_i == RA_LIST);
  assign wr_base  = we_i && (addr_i == RA_BASE);
  assign wr_stage = we_i && (addr_i == RA_STAGE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= 1'b0;
      te_q    <= 1'b0;
      se_q    <= 1'b0;
      tie_q   <= 1'b0;
      sie_q   <= 1'b0;
      rpt_q   <= 1'b0;
      dmode_q <= 1'b0;
      base_q  <= '0;
      cnt_q   <= '0;
      stage_q <= '0;
      sar_q   <= '0;
      dar_q   <= '0;
      tcr_q   <= '0;
    end else begin
      if (wr_ctrl) begin
        en_q  <= wdata_i[B_EN];
        tie_q <= wdata_i[B_TIE];
        sie_q <= wdata_i[B_SIE];
        rpt_q <= wdata_i[B_RPT];
      end
      // hardware set has priority over a software clear
      te_q <= te_set_i    | (te_q & ~(wr_ctrl & ~wdata_i[B_TE]));
      se_q <= stage_set_i | (se_q & ~(wr_ctrl & ~wdata_i[B_SE]));
      if (wr_list)  cnt_q <= wdata_i[CNT_LSB +: IDX_W];
      if (wr_base) begin
        base_q  <= wdata_i[DW-1:4];
        dmode_q <= wdata_i[B_MODE];
      end
      if (wr_stage) stage_q <= wdata_i[IDX_W-1:0];
      if (we_i && addr_i == RA_SRC) sar_q <= wdata_i;
      if (we_i && addr_i == RA_DST) dar_q <= wdata_i;
      if (we_i && addr_i == RA_CNT) tcr_q <= wdata_i;
    end
  end

  assign start_o   = wr_ctrl & wdata_i[B_EN] & ~en_q;
  assign stop_o    = wr_ctrl & ~wdata_i[B_EN];
  assign idx_clr_o = wr_list & wdata_i[B_IRST];

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      RA_CTRL: begin
        rdata_o[B_EN]  = en_q;
        rdata_o[B_TE]  = te_q;
        rdata_o[B_SE]  = se_q;
        rdata_o[B_TIE] = tie_q;
        rdata_o[B_SIE] = sie_q;
        rdata_o[B_RPT] = rpt_q;
      end
      RA_LIST: begin
        rdata_o[CNT_LSB +: IDX_W] = cnt_q;
        rdata_o[IDX_LSB +: IDX_W] = idx_i;
      end
      RA_BASE:  rdata_o = {base_q, 3'b000, dmode_q};
      RA_STAGE: rdata_o[IDX_W-1:0] = stage_q;
      RA_SRC:   rdata_o = sar_q;
      RA_DST:   rdata_o = dar_q;
      RA_CNT:   rdata_o = tcr_q;
      default:  rdata_o = '0;
    endcase
  end

  assign en_o    = en_q;
  assign rpt_o   = rpt_q;
  assign dmode_o = dmode_q;
  assign te_o    = te_q;
  assign se_o    = se_q;
  assign tie_o   = tie_q;
  assign sie_o   = sie_q;
  assign base_o  = base_q;
  assign cnt_o   = cnt_q;
  assign stage_o = stage_q;
  assign sar_o   = sar_q;
  assign dar_o   = dar_q;
  assign tcr_o   = tcr_q;
endmodule

// File: rtl/dls_fetch.sv
module dls_fetch
  import dls_pkg::*;
#(
  parameter int DW    = 32,
  parameter int IDX_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              en_i,
  input  logic              dmode_i,
  input  logic              rpt_i,
  input  logic [DW-5:0]     base_i,
  input  logic [IDX_W-1:0]  cnt_i,
  input  logic [IDX_W-1:0]  stage_i,
  input  logic              idx_clr_i,
  input  logic [DW-1:0]     sar_i,
  input  logic [DW-1:0]     dar_i,
  input  logic [DW-1:0]     tcr_i,
  output logic              mem_req_o,
  output logic [DW-1:0]     mem_addr_o,
  input  logic              mem_rvalid_i,
  input  logic [DW-1:0]     mem_rdata_i,
  output logic              xfer_load_o,
  output logic [DW-1:0]     xfer_src_o,
  output logic [DW-1:0]     xfer_dst_o,
  output logic [DW-1:0]     xfer_cnt_o,
  input  logic              xfer_done_i,
  output logic [IDX_W-1:0]  idx_o,
  output seq_state_e        state_o,
  output logic              stage_set_o,
  output logic              te_set_o
);
  localparam logic [IDX_W-1:0] IDX_ONE = {{(IDX_W-1){1'b0}}, 1'b1};

  seq_state_e       state_q;
  logic [IDX_W-1:0] idx_q;
  logic [1:0]       wcnt_q;
  logic [DW-1:0]    w_src_q, w_dst_q, w_cnt_q;
  logic             last_entry;

  assign last_entry = (idx_q == cnt_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      wcnt_q  <= '0;
      w_src_q <= '0;
      w_dst_q <= '0;
      w_cnt_q <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            wcnt_q  <= '0;
            state_q <= dmode_i ? ST_FETCH : ST_LOAD;
          end
        end
        ST_FETCH: begin
          if (mem_rvalid_i) begin
            unique case (wcnt_q)
              2'd0: w_src_q <= mem_rdata_i;
              2'd1: w_dst_q <= mem_rdata_i;
              2'd2: w_cnt_q <= mem_rdata_i;
              default: ; // reserved word dropped
            endcase
            wcnt_q <= wcnt_q + 2'd1;
            if (wcnt_q == 2'd3) state_q <= ST_LOAD;
          end
        end
        ST_LOAD: state_q <= ST_WAIT;
        ST_WAIT: if (xfer_done_i) state_q <= ST_ADV;
        ST_ADV: begin
          wcnt_q <= '0;
          if (!dmode_i) begin
            state_q <= ST_IDLE;
          end else if (last_entry) begin
            if (rpt_i) begin
              idx_q   <= '0;
              state_q <= ST_FETCH;
            end else begin
              state_q <= ST_IDLE;
            end
          end else begin
            idx_q   <= idx_q + IDX_ONE;
            state_q <= ST_FETCH;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
      if (!start_i && (stop_i || !en_i)) state_q <= ST_IDLE;
      if (idx_clr_i) idx_q <= '0;
    end
  end

  assign mem_req_o  = (state_q == ST_FETCH);
  assign mem_addr_o = {base_i, 4'b0000}
                    + {{(DW-IDX_W-4){1'b0}}, idx_q, 4'b0000}
                    + {{(DW-4){1'b0}}, wcnt_q, 2'b00};

  assign xfer_load_o = (state_q == ST_LOAD);
  assign xfer_src_o  = dmode_i ? w_src_q : sar_i;
  assign xfer_dst_o  = dmode_i ? w_dst_q : dar_i;
  assign xfer_cnt_o  = dmode_i ? w_cnt_q : tcr_i;

  assign stage_set_o = (state_q == ST_WAIT) && xfer_done_i && dmode_i && (idx_q == stage_i);
  assign te_set_o    = (state_q == ST_ADV) && (!dmode_i || (last_entry && !rpt_i));

  assign idx_o   = idx_q;
  assign state_o = state_q;
endmodule

// File: rtl/desc_list_seq.sv
module desc_list_seq
  import dls_pkg::*;
#(
  parameter int DW    = 32,
  parameter int IDX_W = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_we_i,
  input  logic [2:0]    reg_addr_i,
  input  logic [DW-1:0] reg_wdata_i,
  output logic [DW-1:0] reg_rdata_o,
  output logic          mem_req_o,
  output logic [DW-1:0] mem_addr_o,
  input  logic          mem_rvalid_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          xfer_load_o,
  output logic [DW-1:0] xfer_src_o,
  output logic [DW-1:0] xfer_dst_o,
  output logic [DW-1:0] xfer_cnt_o,
  input  logic          xfer_done_i,
  output logic          irq_o
);
  logic en_w, rpt_w, dmode_w, te_w, se_w, tie_w, sie_w;
  logic start_w, stop_w, idx_clr_w, stage_set_w, te_set_w;
  logic [DW-5:0]    base_w;
  logic [IDX_W-1:0] cnt_w, stage_w, idx_w;
  logic [DW-1:0]    sar_w, dar_w, tcr_w;
  seq_state_e       state_w;

  dls_regs #(.DW(DW), .IDX_W(IDX_W)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (reg_we_i),
    .addr_i      (reg_addr_i),
    .wdata_i     (reg_wdata_i),
    .idx_i       (idx_w),
    .stage_set_i (stage_set_w),
    .te_set_i    (te_set_w),
    .rdata_o     (reg_rdata_o),
    .en_o        (en_w),
    .rpt_o       (rpt_w),
    .dmode_o     (dmode_w),
    .te_o        (te_w),
    .se_o        (se_w),
    .tie_o       (tie_w),
    .sie_o       (sie_w),
    .base_o      (base_w),
    .cnt_o       (cnt_w),
    .stage_o     (stage_w),
    .sar_o       (sar_w),
    .dar_o       (dar_w),
    .tcr_o       (tcr_w),
    .start_o     (start_w),
    .stop_o      (stop_w),
    .idx_clr_o   (idx_clr_w)
  );

  dls_fetch #(.DW(DW), .IDX_W(IDX_W)) u_fetch (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_w),
    .stop_i       (stop_w),
    .en_i         (en_w),
    .dmode_i      (dmode_w),
    .rpt_i        (rpt_w),
    .base_i       (base_w),
    .cnt_i        (cnt_w),
    .stage_i      (stage_w),
    .idx_clr_i    (idx_clr_w),
    .sar_i        (sar_w),
    .dar_i        (dar_w),
    .tcr_i        (tcr_w),
    .mem_req_o    (mem_req_o),
    .mem_addr_o   (mem_addr_o),
    .mem_rvalid_i (mem_rvalid_i),
    .mem_rdata_i  (mem_rdata_i),
    .xfer_load_o  (xfer_load_o),
    .xfer_src_o   (xfer_src_o),
    .xfer_dst_o   (xfer_dst_o),
    .xfer_cnt_o   (xfer_cnt_o),
    .xfer_done_i  (xfer_done_i),
    .idx_o        (idx_w),
    .state_o      (state_w),
    .stage_set_o  (stage_set_w),
    .te_set_o     (te_set_w)
  );

  assign irq_o = (te_w & tie_w) | (se_w & sie_w);
endmodule

// File: rtl/desc_list_seq_chk.sv
module desc_list_seq_chk
  import dls_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       reg_we_i,
  input logic       en_i,
  input logic       start_i,
  input logic       te_i,
  input logic       rpt_i,
  input logic       dmode_i,
  input seq_state_e state_i,
  input logic       mem_req_i,
  input logic       xfer_load_i,
  input logic       irq_i
);
  // R2
  load_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_load_i |=> !xfer_load_i);

  // R2
  fetch_load_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_req_i && xfer_load_i));

  // R10
  stop_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !start_i) |=> (state_i == ST_IDLE));

  // R8
  rpt_no_te_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(te_i) |-> (!rpt_i || !dmode_i));

  // R7
  te_after_adv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(te_i) |-> ($past(state_i) == ST_ADV));

  // R12
  direct_no_mem_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_i |-> dmode_i);

  // R13
  irq_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_i && !reg_we_i) |=> irq_i);
endmodule

bind desc_list_seq desc_list_seq_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_we_i    (reg_we_i),
  .en_i        (en_w),
  .start_i     (start_w),
  .te_i        (te_w),
  .rpt_i       (rpt_w),
  .dmode_i     (dmode_w),
  .state_i     (state_w),
  .mem_req_i   (mem_req_o),
  .xfer_load_i (xfer_load_o),
  .irq_i       (irq_o)
);

// File: tb/desc_list_seq_bench.sv
`timescale 1ns/1ps
module desc_list_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic [31:0] mem_rdata;
  logic        load;
  logic [31:0] src, dst, cnt;
  logic        done = 1'b0;
  logic        irq;

  int checks = 0;
  int errs = 0;
  int load_cnt = 0;
  int req_cnt = 0;
  int served = 0;
  int alog_n = 0;
  logic [31:0] alog [4];
  logic [31:0] cap_src, cap_dst, cap_cnt;

  always #2.5 clk = ~clk;

  function automatic logic [31:0] memfn(input logic [31:0] a);
    return {~a[15:0], a[15:0]};
  endfunction

  assign mem_rdata = memfn(mem_addr);

  desc_list_seq u_desc_list_seq (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr),
    .mem_rvalid_i(mem_req), .mem_rdata_i(mem_rdata),
    .xfer_load_o(load), .xfer_src_o(src), .xfer_dst_o(dst), .xfer_cnt_o(cnt),
    .xfer_done_i(done), .irq_o(irq)
  );

  // monitor away from the active edge
  always @(negedge clk) begin
    if (load) begin
      load_cnt = load_cnt + 1;
      cap_src = src; cap_dst = dst; cap_cnt = cnt;
    end
    if (mem_req) begin
      req_cnt = req_cnt + 1;
      if (alog_n < 4) begin
        alog[alog_n] = mem_addr;
        alog_n = alog_n + 1;
      end
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic wait_load(input string tag);
    int t;
    t = 0;
    while (load_cnt <= served && t < 400) begin @(negedge clk); t++; end
    if (t >= 400) begin
      checks++; errs++;
      $display("FAIL %s no load act=0 exp=1", tag);
    end
    served = load_cnt;
  endtask

  task automatic pulse_done();
    @(negedge clk); done = 1'b1;
    @(negedge clk); done = 1'b0;
  endtask

  task automatic serve(input int idx, input logic [31:0] base, input string tag);
    logic [31:0] a;
    wait_load(tag);
    a = base + idx * 16;
    check(tag, cap_src, memfn(a));
    check(tag, cap_dst, memfn(a + 32'd4));
    check(tag, cap_cnt, memfn(a + 32'd8));
    pulse_done();
  endtask

  // {count-1, stage index, table base}
  localparam logic [47:0] VEC [4] = '{
    48'h00_00_0000_1000,
    48'h02_01_0002_0040,
    48'h04_09_00AB_CD00,
    48'h07_07_0000_0FF0
  };

  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    $display("FAIL watchdog act=hung exp=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int l0, r0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(3'd0, d); check("R1 ctrl", d, 32'h0);
    rd(3'd1, d); check("R1 list", d, 32'h0);
    rd(3'd2, d); check("R1 base", d, 32'h0);
    check("R1 irq", {31'b0, irq}, 32'h0);
    check("R1 req", {31'b0, mem_req}, 32'h0);
    check("R1 load", {31'b0, load}, 32'h0);

    // single-pass vector table: R4 R5 R7
    for (int v = 0; v < 4; v++) begin
      logic [7:0]  vc, vs;
      logic [31:0] vb;
      vc = VEC[v][47:40]; vs = VEC[v][39:32]; vb = VEC[v][31:0];
      wr(3'd1, {vc, 8'h00, 16'h8000});
      wr(3'd2, vb | 32'h1);
      wr(3'd3, {24'h0, vs});
      served = load_cnt; l0 = load_cnt;
      wr(3'd0, 32'h09);
      for (int k = 0; k <= int'(vc); k++) serve(k, vb, "R2 table");
      repeat (3) @(negedge clk);
      rd(3'd0, d);
      check("R7 table ctrl", d, 32'h0B | ((vs <= vc) ? 32'h4 : 32'h0));
      check("R13 table irq", {31'b0, irq}, 32'h1);
      check("R4 table loads", load_cnt - l0, int'(vc) + 1);
      rd(3'd1, d); check("R5 table index", d, {vc, vc, 16'h0});
      wr(3'd0, 32'h0);
    end

    // R5 index reset strobe
    wr(3'd1, 32'h0000_8000);
    rd(3'd1, d); check("R5 index reset", d, 32'h0);

    // R3 base low bits, R2 word order
    wr(3'd2, 32'h0000_300F);
    rd(3'd2, d); check("R3 base readback", d, 32'h0000_3001);
    alog_n = 0; r0 = req_cnt; served = load_cnt;
    wr(3'd0, 32'h01);
    serve(0, 32'h3000, "R2 single");
    for (int i = 0; i < 4; i++) check("R2 addr order", alog[i], 32'h3000 + i * 4);
    check("R2 four reads", req_cnt - r0, 4);
    wr(3'd0, 32'h0);

    // R6 stage event, moved pointer, R9, R13, R7 gating
    wr(3'd1, {8'd2, 8'h00, 16'h8000});
    wr(3'd2, 32'h0000_4001);
    wr(3'd3, 32'd1);
    served = load_cnt;
    wr(3'd0, 32'h11);
    serve(0, 32'h4000, "R2 stage");
    rd(3'd0, d); check("R6 no early stage", d, 32'h11);
    serve(1, 32'h4000, "R2 stage");
    @(negedge clk);
    rd(3'd0, d); check("R6 stage hit", d, 32'h15);
    check("R6 stage irq", {31'b0, irq}, 32'h1);
    repeat (3) @(negedge clk);
    check("R13 level held", {31'b0, irq}, 32'h1);
    wr(3'd3, 32'd2);
    wr(3'd0, 32'h11);
    rd(3'd0, d); check("R9 clear stage", d, 32'h11);
    check("R13 irq drops", {31'b0, irq}, 32'h0);
    serve(2, 32'h4000, "R2 stage");
    repeat (3) @(negedge clk);
    rd(3'd0, d); check("R6 later stage", d, 32'h17);
    wr(3'd0, 32'h13);
    rd(3'd0, d); check("R9 write one keeps", d, 32'h13);
    check("R7 te masked", {31'b0, irq}, 32'h0);
    wr(3'd0, 32'h0);
    rd(3'd0, d); check("R10 halt clears", d, 32'h0);

    // R11 set vs clear in one cycle
    wr(3'd1, {8'd1, 8'h00, 16'h8000});
    wr(3'd2, 32'h0000_5001);
    wr(3'd3, 32'd0);
    served = load_cnt;
    wr(3'd0, 32'h11);
    wait_load("R11");
    @(negedge clk);
    done = 1'b1; we = 1'b1; addr = 3'd0; wdata = 32'h11;
    @(negedge clk);
    done = 1'b0; we = 1'b0;
    rd(3'd0, d); check("R11 set wins", d, 32'h15);
    serve(1, 32'h5000, "R2 collide");
    repeat (3) @(negedge clk);
    wr(3'd0, 32'h0);

    // R8 endless mode, R10 stop
    wr(3'd1, {8'd1, 8'h00, 16'h8000});
    wr(3'd2, 32'h0000_6001);
    wr(3'd3, 32'd1);
    served = load_cnt;
    wr(3'd0, 32'h21);
    for (int k = 0; k < 5; k++) serve(k % 2, 32'h6000, "R8 wrap");
    repeat (3) @(negedge clk);
    rd(3'd0, d); check("R8 no te", d, 32'h25);
    wr(3'd0, 32'h0);
    l0 = load_cnt; r0 = req_cnt;
    repeat (20) @(negedge clk);
    check("R10 no loads", load_cnt - l0, 0);
    check("R10 no reads", req_cnt - r0, 0);
    rd(3'd0, d); check("R10 ctrl zero", d, 32'h0);

    // R12 direct mode
    wr(3'd2, 32'h0);
    wr(3'd4, 32'h1111_0000);
    wr(3'd5, 32'h2222_0000);
    wr(3'd6, 32'h0000_0040);
    r0 = req_cnt; served = load_cnt;
    wr(3'd0, 32'h09);
    wait_load("R12");
    check("R12 src", cap_src, 32'h1111_0000);
    check("R12 dst", cap_dst, 32'h2222_0000);
    check("R12 cnt", cap_cnt, 32'h0000_0040);
    pulse_done();
    repeat (3) @(negedge clk);
    rd(3'd0, d); check("R12 te", d, 32'h0B);
    check("R7 te irq", {31'b0, irq}, 32'h1);
    check("R12 no reads", req_cnt - r0, 0);
    wr(3'd0, 32'h0);

    $display("CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end
endmodule